// File: doc/BRIEF.md
# Float Reciprocal Root Estimator

This block produces a seed estimate of either 1/x or 1/sqrt(x) for one IEEE single-precision operand. The seed is intended as the starting point of later Newton-Raphson refinement carried out elsewhere, so it aims for roughly 14 to 15 correct significand bits rather than a correctly rounded result.

The operand is the low word of a 64-bit source bus. The 32-bit estimate is copied into every 32-bit lane of the result bus. A one-bit mode input chooses between the reciprocal and the reciprocal square root.

Internally the leading mantissa bits index small tables of sample points that are computed at elaboration. The remaining mantissa bits interpolate linearly between neighbouring points. Exponent arithmetic then places the result. For the square root, the parity of the exponent field picks one of two tables: one covers a mantissa range of [1,2) and the other [2,4). The estimate is computed combinationally and registered once, so a valid strobe returns exactly one cycle after the request.

Top module: `recip_root_seed`

## Requirements
- R1: After reset, `out_valid` is 0 and `result` is 0. `out_valid` is high in exactly the cycle after one in which `in_valid` was high.
- R2: While `in_valid` is low, `result` keeps its last value whatever `src` and `mode` do.
- R3: Bits [63:32] of `src` have no effect on the estimate.
- R4: `result[63:32]` always equals `result[31:0]`.
- R5: With `mode`=0 (reciprocal), for a normal input (exponent field 1..254) whose true reciprocal is at least 2^-126, the relative error of the estimate is below 2^-14.
- R6: With `mode`=1 (reciprocal square root), for every normal input, odd or even exponent field, the relative error against 1/sqrt(|x|) is below 2^-15.
- R7: In both modes the result sign bit (bit 31) equals the input sign bit. A negative input to the square-root mode is processed as its magnitude.
- R8: An input with a zero mantissa field gives an exact result in reciprocal mode. In square-root mode the result is exact when the mantissa field is zero and the exponent field is odd. Examples: 1/2.0 = 0x3F000000 and 1/sqrt(4.0) = 0x3F000000.
- R9: An input with exponent field 0 (zero, or a denormal treated as zero) gives infinity with the input sign: exponent field 0xFF, mantissa 0.
- R10: An input with exponent field 0xFF gives zero with the input sign.
- R11: In reciprocal mode, a result whose true value is below 2^-126 is flushed to zero with the input sign. Examples are exponent field 253 with a nonzero mantissa, and exponent field 254.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe; `src` and `mode` are taken in this cycle |
| mode | input | 1 | 0 = reciprocal, 1 = reciprocal square root |
| src | input | 64 | Source; only bits [31:0] carry the operand |
| out_valid | output | 1 | High one cycle after an accepted request |
| result | output | 64 | Estimate broadcast into both 32-bit lanes |

## Verification
The clocked properties assume that `in_valid`, `mode` and `src` are driven to known values in every cycle after reset. They also assume that exponent field 0 and exponent field 0xFF are the only special encodings the block must recognise, with NaN payloads treated like infinities. The random stimulus draws exponent fields only from 1 to 254 and fills the unused upper source word with random data. Zero, all-ones exponents, powers of two and the underflow edge are reached only through directed cases, so the accuracy properties are never applied to encodings outside their domain.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

   localparam int SP_EXP_W = 8;
   localparam int SP_MAN_W = 23;
   localparam int SP_W     = 1 + SP_EXP_W + SP_MAN_W;
   // seed point: unsigned fixed point, 1.0 == 2**(SP_MAN_W+1)
   localparam int PT_W     = SP_MAN_W + 2;

   typedef enum logic {
      RRS_RECIP = 1'b0,
      RRS_RSQRT = 1'b1
   } rrs_mode_e;

   typedef enum logic [1:0] {
      LUT_RECIP    = 2'd0,
      LUT_RSQ_LOW  = 2'd1,   // mantissa range [1,2), odd exponent field
      LUT_RSQ_HIGH = 2'd2    // mantissa range [2,4), even exponent field
   } lut_kind_e;

   typedef struct packed {
      logic                sign;
      logic [SP_EXP_W-1:0] expo;
      logic [SP_MAN_W-1:0] man;
   } sp_word_t;

   // floor(sqrt(n)) by restoring bit search
   function automatic logic [31:0] isqrt64(input logic [63:0] n);
      logic [63:0] root;
      logic [63:0] trial;
      root = '0;
      for (int b = 31; b >= 0; b--) begin
         trial = root | (64'd1 << b);
         if (trial * trial <= n) root = trial;
      end
      return root[31:0];
   endfunction

   // sample point idx of a table with 2**ib segments
   function automatic logic [PT_W-1:0] seed_point(input int kind, input int idx, input int ib);
      logic [63:0] den;
      logic [63:0] q;
      den = 64'((1 << ib) + idx);
      case (kind)
         0:       q = (64'd1 << (PT_W - 1 + ib)) / den;
         1:       q = 64'(isqrt64((64'd1 << (2 * (PT_W - 1) + ib)) / den));
         default: q = 64'(isqrt64((64'd1 << (2 * (PT_W - 1) + ib - 1)) / den));
      endcase
      return q[PT_W-1:0];
   endfunction

endpackage

// File: rtl/rrs_seed_lut.sv
module rrs_seed_lut
   import rrs_pkg::*;
#(
   parameter int IDX_BITS = 8,
   parameter int KIND     = 0
) (
   input  logic [IDX_BITS-1:0] idx_i,
   output logic [PT_W-1:0]     lo_pt_o,
   output logic [PT_W-1:0]     hi_pt_o
);

   localparam int N_PTS = (1 << IDX_BITS) + 1;
   localparam int AW    = IDX_BITS + 1;

   if (KIND < 0 || KIND > 2) begin : g_bad_kind
      $error("rrs_seed_lut: KIND must be 0, 1 or 2");
   end

   logic [PT_W-1:0] pts [N_PTS];
   logic [AW-1:0]   lo_a;
   logic [AW-1:0]   hi_a;

   for (genvar g = 0; g < N_PTS; g++) begin : g_pt
      localparam logic [PT_W-1:0] PT = seed_point(KIND, g, IDX_BITS);
      assign pts[g] = PT;
   end

   assign lo_a    = {1'b0, idx_i};
   assign hi_a    = lo_a + AW'(1);
   assign lo_pt_o = pts[lo_a];
   assign hi_pt_o = pts[hi_a];

endmodule

// File: rtl/rrs_interp.sv
module rrs_interp
   import rrs_pkg::*;
#(
   parameter int FRAC_BITS = 15,
   parameter bit ROUND     = 1'b0
) (
   input  logic [PT_W-1:0]      lo_pt_i,
   input  logic [PT_W-1:0]      hi_pt_i,
   input  logic [FRAC_BITS-1:0] frac_i,
   output logic [PT_W-1:0]      seed_o
);

   localparam int PROD_W = PT_W + FRAC_BITS;

   if (FRAC_BITS < 1) begin : g_bad_frac
      $error("rrs_interp: FRAC_BITS must be positive");
   end

   logic [PT_W-1:0]   step;
   logic [PROD_W-1:0] prod;
   logic [PROD_W-1:0] prod_adj;
   logic [PT_W-1:0]   drop;

   assign step = lo_pt_i - hi_pt_i;
   assign prod = PROD_W'(step) * PROD_W'(frac_i);

   if (ROUND) begin : g_round
      assign prod_adj = prod + (PROD_W'(1) << (FRAC_BITS - 1));
   end else begin : g_trunc
      assign prod_adj = prod;
   end

   assign drop   = prod_adj[PROD_W-1:FRAC_BITS];
   assign seed_o = lo_pt_i - drop;

   always_comb begin
      AST_SEED_BRACKET: assert (seed_o <= lo_pt_i && seed_o >= hi_pt_i)
         else $error("interpolated seed left its segment"); // R5
   end

endmodule

// File: rtl/rrs_exp_path.sv
module rrs_exp_path
   import rrs_pkg::*;
(
   input  rrs_mode_e           mode_i,
   input  logic                sign_i,
   input  logic [SP_EXP_W-1:0] expo_i,
   input  logic [PT_W-1:0]     seed_i,
   output logic [SP_W-1:0]     word_o
);

   localparam int EW = SP_EXP_W + 3;

   logic                 seed_full;
   logic [SP_MAN_W-1:0]  man_out;
   logic signed [EW-1:0] rcp_exp;
   logic [EW-1:0]        rsq_sum;
   logic [EW-1:0]        rsq_exp;
   logic                 exp_zero;
   logic                 exp_ones;

   assign seed_full = seed_i[PT_W-1];
   assign man_out   = seed_full ? '0 : seed_i[SP_MAN_W-1:0];
   assign exp_zero  = (expo_i == '0);
   assign exp_ones  = (expo_i == '1);

   // reciprocal: 253 - e, plus one when the seed is exactly 1.0
   assign rcp_exp = $signed(EW'(253)) - $signed({3'b000, expo_i})
                  + $signed({{(EW-1){1'b0}}, seed_full});
   // square root: floor((380 - e) / 2), plus one when the seed is exactly 1.0
   assign rsq_sum = EW'(380) - {3'b000, expo_i};
   assign rsq_exp = (rsq_sum >> 1) + {{(EW-1){1'b0}}, seed_full};

   always_comb begin
      if (exp_zero)
         word_o = {sign_i, {SP_EXP_W{1'b1}}, {SP_MAN_W{1'b0}}};
      else if (exp_ones)
         word_o = {sign_i, {(SP_W-1){1'b0}}};
      else if (mode_i == RRS_RSQRT)
         word_o = {sign_i, rsq_exp[SP_EXP_W-1:0], man_out};
      else if (rcp_exp <= $signed(EW'(0)))
         word_o = {sign_i, {(SP_W-1){1'b0}}};
      else
         word_o = {sign_i, rcp_exp[SP_EXP_W-1:0], man_out};
   end

   always_comb begin
      AST_SEED_NORM: assert (seed_i[PT_W-1] || seed_i[PT_W-2])
         else $error("seed below 0.5"); // R5
      AST_SEED_EXACT: assert (!seed_full || seed_i[PT_W-2:0] == '0)
         else $error("seed above 1.0"); // R8
      AST_RSQ_EXP_RANGE: assert (exp_zero || exp_ones || (rsq_exp >= EW'(63) && rsq_exp <= EW'(190)))
         else $error("square-root exponent out of range"); // R6
   end

endmodule

// File: rtl/recip_root_seed.sv
module recip_root_seed
   import rrs_pkg::*;
#(
   parameter int IDX_BITS = 8,
   parameter int LANES    = 2,
   parameter bit ROUND    = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic                  mode,
   input  logic [LANES*SP_W-1:0] src,
   output logic                  out_valid,
   output logic [LANES*SP_W-1:0] result
);

   localparam int FRAC_BITS = SP_MAN_W - IDX_BITS;
   localparam int N_LUT     = 3;
   localparam int BUS_W     = LANES * SP_W;

   if (IDX_BITS < 4 || IDX_BITS > 12) begin : g_bad_idx
      $error("recip_root_seed: IDX_BITS must lie in 4..12");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("recip_root_seed: LANES must be at least 1");
   end

   sp_word_t              in_w;
   rrs_mode_e             mode_e;
   lut_kind_e             lut_sel;
   logic [IDX_BITS-1:0]   idx;
   logic [FRAC_BITS-1:0]  frac;
   logic [PT_W-1:0]       lo_pts [N_LUT];
   logic [PT_W-1:0]       hi_pts [N_LUT];
   logic [PT_W-1:0]       lo_pt;
   logic [PT_W-1:0]       hi_pt;
   logic [PT_W-1:0]       seed;
   logic [SP_W-1:0]       est;
   logic [SP_W-1:0]       est_q;
   logic                  valid_q;
   logic                  unused_upper;

   assign in_w         = src[SP_W-1:0];
   assign unused_upper = ^src[BUS_W-1:SP_W];
   assign mode_e       = rrs_mode_e'(mode);
   assign idx          = in_w.man[SP_MAN_W-1 -: IDX_BITS];
   assign frac         = in_w.man[FRAC_BITS-1:0];

   for (genvar k = 0; k < N_LUT; k++) begin : g_lut
      rrs_seed_lut #(
         .IDX_BITS (IDX_BITS),
         .KIND     (k)
      ) u_lut (
         .idx_i   (idx),
         .lo_pt_o (lo_pts[k]),
         .hi_pt_o (hi_pts[k])
      );
   end

   always_comb begin
      if (mode_e == RRS_RECIP)
         lut_sel = LUT_RECIP;
      else if (in_w.expo[0])
         lut_sel = LUT_RSQ_LOW;
      else
         lut_sel = LUT_RSQ_HIGH;
   end

   always_comb begin
      case (lut_sel)
         LUT_RSQ_LOW:  begin lo_pt = lo_pts[1]; hi_pt = hi_pts[1]; end
         LUT_RSQ_HIGH: begin lo_pt = lo_pts[2]; hi_pt = hi_pts[2]; end
         default:      begin lo_pt = lo_pts[0]; hi_pt = hi_pts[0]; end
      endcase
   end

   rrs_interp #(
      .FRAC_BITS (FRAC_BITS),
      .ROUND     (ROUND)
   ) u_interp (
      .lo_pt_i (lo_pt),
      .hi_pt_i (hi_pt),
      .frac_i  (frac),
      .seed_o  (seed)
   );

   rrs_exp_path u_exp (
      .mode_i (mode_e),
      .sign_i (in_w.sign),
      .expo_i (in_w.expo),
      .seed_i (seed),
      .word_o (est)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         est_q   <= '0;
      end else begin
         valid_q <= in_valid;
         if (in_valid) est_q <= est;
      end
   end

   assign out_valid = valid_q;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign result[l*SP_W +: SP_W] = est_q;
   end

   AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid) else $error("missing strobe"); // R1
   AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid) else $error("spurious strobe"); // R1
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(result)) else $error("result moved while idle"); // R2
   AST_SIGN_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> result[SP_W-1] == $past(src[SP_W-1])) else $error("sign lost"); // R7
   AST_ZERO_TO_INF: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && src[SP_W-2 -: SP_EXP_W] == '0) |=> result[SP_W-2:0] == {{SP_EXP_W{1'b1}}, {SP_MAN_W{1'b0}}})
      else $error("zero input did not give infinity"); // R9
   AST_INF_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && src[SP_W-2 -: SP_EXP_W] == '1) |=> result[SP_W-2:0] == '0)
      else $error("infinite input did not give zero"); // R10

endmodule

// File: tb/recip_root_seed_test.sv
module recip_root_seed_test;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        mode = 1'b0;
   logic [63:0] src = '0;
   logic        out_valid;
   logic [63:0] result;
   int          checks = 0;
   int          errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   recip_root_seed uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .mode      (mode),
      .src       (src),
      .out_valid (out_valid),
      .result    (result)
   );

   function automatic real pow2(input int n);
      real r = 1.0;
      if (n >= 0) for (int i = 0; i < n; i++) r = r * 2.0;
      else        for (int i = 0; i < -n; i++) r = r / 2.0;
      return r;
   endfunction

   function automatic real mag_of(input logic [31:0] w);
      if (w[30:23] == 8'd0) return 0.0;
      return (1.0 + real'(w[22:0]) / 8388608.0) * pow2(int'(w[30:23]) - 127);
   endfunction

   task automatic chk_bits(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic chk_rel(input string req, input logic [31:0] got_w, input real want, input real tol);
      real got, rel;
      got = mag_of(got_w);
      rel = (got > want) ? (got - want) / want : (want - got) / want;
      checks++;
      if (rel >= tol) begin
         errors++;
         $display("FAIL %s: actual %h (%g) expected %g relerr %g", req, got_w, got, want, rel);
      end
   endtask

   task automatic apply(input logic m, input logic [63:0] s);
      @(negedge clk);
      mode = m; src = s; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   // full check of one request against values derived from the requirements
   task automatic run_case(input logic m, input logic [31:0] lo, input logic [31:0] hi);
      logic       sg;
      int         e;
      real        x, want;
      sg = lo[31];
      e  = int'(lo[30:23]);
      apply(m, {hi, lo});
      chk_bits("R1 strobe", {63'd0, out_valid}, 64'd1);
      chk_bits("R4 lanes", {32'd0, result[63:32]}, {32'd0, result[31:0]});
      if (e == 0) begin
         chk_bits("R9 zero in", {32'd0, result[31:0]}, {32'd0, sg, 8'hFF, 23'd0});
      end else if (e == 255) begin
         chk_bits("R10 inf in", {32'd0, result[31:0]}, {32'd0, sg, 31'd0});
      end else begin
         x = (1.0 + real'(lo[22:0]) / 8388608.0) * pow2(e - 127);
         chk_bits("R7 sign", {63'd0, result[31]}, {63'd0, sg});
         if (m == 1'b0) begin
            want = 1.0 / x;
            if (want < pow2(-126))
               chk_bits("R11 flush", {32'd0, result[31:0]}, {32'd0, sg, 31'd0});
            else
               chk_rel("R5 recip", result[31:0], want, pow2(-14));
         end else begin
            want = 1.0 / $sqrt(x);
            chk_rel("R6 rsqrt", result[31:0], want, pow2(-15));
         end
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [63:0] saved;
      logic [31:0] w;
      void'($urandom(32'd914_27));
      repeat (3) @(negedge clk);
      chk_bits("R1 reset valid", {63'd0, out_valid}, 64'd0);
      chk_bits("R1 reset result", result, 64'd0);
      rst_n = 1'b1;

      // R8 exact powers of two
      run_case(1'b0, 32'h3F800000, 32'h0);
      chk_bits("R8 recip 1.0", result, {2{32'h3F800000}});
      run_case(1'b0, 32'h40000000, 32'hDEADBEEF);
      chk_bits("R8 recip 2.0", result, {2{32'h3F000000}});
      run_case(1'b0, 32'h00800000, 32'h0);
      chk_bits("R8 recip 2^-126", result, {2{32'h7E800000}});
      run_case(1'b1, 32'h40800000, 32'h0);
      chk_bits("R8 rsqrt 4.0", result, {2{32'h3F000000}});
      run_case(1'b1, 32'h3F800000, 32'h0);
      chk_bits("R8 rsqrt 1.0", result, {2{32'h3F800000}});
      run_case(1'b1, 32'h40000000, 32'h0);               // R6 even exponent
      // R7 negative operands
      run_case(1'b1, 32'hC0800000, 32'h0);
      chk_bits("R7 rsqrt -4.0", result, {2{32'hBF000000}});
      run_case(1'b0, 32'hC0400000, 32'h0);
      // R9 / R10 specials in both modes
      run_case(1'b0, 32'h00000000, 32'h0);
      run_case(1'b1, 32'h80000000, 32'h0);
      run_case(1'b0, 32'h7F800000, 32'h0);
      run_case(1'b1, 32'hFF800000, 32'h0);
      // R11 underflow edge
      run_case(1'b0, 32'h7E800000, 32'h0);
      chk_bits("R11 edge exact", result, {2{32'h00800000}});
      run_case(1'b0, 32'h7E800001, 32'h0);
      run_case(1'b0, 32'hFF000000, 32'h0);

      // R3 upper word ignored
      w = 32'h40490FDB;
      run_case(1'b1, w, 32'h0);
      saved = result;
      run_case(1'b1, w, 32'hFFFFFFFF);
      chk_bits("R3 upper ignored", result, saved);

      // R2 hold while idle
      @(negedge clk);
      src = {$urandom(), $urandom()}; mode = ~mode;
      @(negedge clk);
      chk_bits("R2 idle valid", {63'd0, out_valid}, 64'd0);
      chk_bits("R2 hold", result, saved);

      // constrained random: normal exponent fields only
      for (int n = 0; n < 600; n++) begin
         logic m;
         m = n[0];
         w = {$urandom_range(1, 0) == 1 ? 1'b1 : 1'b0, 8'($urandom_range(254, 1)), 23'($urandom())};
         run_case(m, w, $urandom());
         if (n % 50 == 0) begin
            saved = result;
            @(negedge clk);
            src = {$urandom(), $urandom()};
            @(negedge clk);
            chk_bits("R2 hold random", result, saved);
         end
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule